// File: doc/BRIEF.md
# USB Host Dual-Speed Transmit Sequencer

This block is the bit-level transmit engine of a USB host port. It turns a command and a stream of complete packet bytes into line states on the two data wires (J, K or single-ended zero), with NRZI coding and bit stuffing applied on the fly. An internal bit-rate divider sets the length of each bit. Between bits it can be switched from full speed (12 Mbps) to low speed, which is eight times slower.

Three commands exist. The first sends a full-speed packet. The second reaches a low-speed device behind a full-speed hub: a full-speed SYNC and the preamble token go out first, then a stretch of J at full speed, then the low-speed SYNC and packet. No end-of-packet appears until the low-speed packet is complete. The third drives a long bus reset. The line polarity is the full-speed one throughout, because the hub inverts the polarity toward its low-speed ports. The block also tells the paired receiver which rate to expect. It selects low speed only after a low-speed packet has ended, and keeps it until a reply arrives or a wait limit runs out.

Top module: `usb_host_tx_seq`

## Requirements
- R1: After reset the output driver is off (`usb_oe`=0), the wires sit at J (`usb_dp`=1, `usb_dm`=0), and `busy`, `done`, `rx_low` and `byte_ack` are 0.
- R2: Command code 1 sends a full-speed packet. The sync byte 0x80 goes first, then `cmd_len` bytes, each byte least significant bit first. The NRZI coding starts from J: a 0 bit toggles J/K and a 1 bit holds the line. Each bit lasts `FS_DIV` clocks, and the driver turns on with the first bit.
- R3: After six 1 bits in a row, a toggling stuff bit is inserted. This also applies when the run ends the last byte, in which case the stuff bit comes before the end-of-packet.
- R4: The end-of-packet is two bit times of SE0 (`usb_dp`=`usb_dm`=0) and then one bit time of J, at the current rate. After it the driver turns off, `done` is high for exactly one clock, and `busy` falls.
- R5: Command code 2 first sends, at full speed, the sync byte and then the preamble token 0x3C. SE0 does not appear on the line from then until the final end-of-packet.
- R6: After the preamble token the driver stays on and drives J for `GAP_BITS` full-speed bit times.
- R7: After the J gap, the sync byte and `cmd_len` bytes go out at low speed, with each bit lasting 8×`FS_DIV` clocks. The NRZI restarts from J, and J and K keep the same wire polarity as at full speed.
- R8: After a low-speed packet the transmitter is back at full speed, so the next full-speed packet uses `FS_DIV`-clock bits.
- R9: Command code 3 drives SE0 for `RESET_BITS`×`FS_DIV` clocks and then turns the driver off with `done`.
- R10: `rx_low` rises together with `done` at the end of a low-speed packet, and only then. It falls the clock after `rx_reply` is seen, or after it has been high for `RESP_TO` clocks.
- R11: A command presented while `busy` is high, or with code 0, is dropped and has no later effect.
- R12: Each packet byte is taken from `tx_byte` when its turn comes, and `byte_ack` pulses once for each byte taken, `cmd_len` times in total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, accepted only while idle |
| cmd_op | input | 2 | 0 none, 1 full-speed packet, 2 low-speed packet with preamble, 3 bus reset |
| cmd_len | input | LEN_W | Packet byte count after the sync byte |
| tx_byte | input | 8 | Current packet byte; advance it after each `byte_ack` |
| byte_ack | output | 1 | One-clock pulse: `tx_byte` was taken |
| rx_reply | input | 1 | Receiver saw the awaited reply |
| usb_dp | output | 1 | Positive data wire level |
| usb_dm | output | 1 | Negative data wire level |
| usb_oe | output | 1 | Line driver enable |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-clock pulse when a command ends |
| rx_low | output | 1 | Receiver should expect low speed |

## Verification
The bench compares the line, clock by clock, with a model built from the requirements. Any error in a bit length, a polarity or a stuff position therefore shows up as a mismatch at a definite sample. It aims at the rate switch after the preamble: a design that switches one bit too early stretches the last gap bit to a low-speed length, and one that puts out an end-of-packet after the preamble shows SE0 in the middle of the frame. Runs of ones that end a byte and a packet expose a design that drops the stuff bit before the end-of-packet. The bench also measures how long `rx_low` stays high and sends a full-speed packet after a low-speed one. These catch a receive rate that never times out and a divider left at the slow rate.

// File: rtl/usbtx_pkg.sv
package usbtx_pkg;

    localparam int unsigned LS_RATIO  = 8;
    localparam int unsigned STUFF_RUN = 6;
    localparam logic [7:0]  SYNC_PAT  = 8'h80;
    localparam logic [7:0]  PRE_TOKEN = 8'h3C;

    typedef enum logic [1:0] {
        OP_NONE   = 2'd0,
        OP_FULL   = 2'd1,
        OP_LOW    = 2'd2,
        OP_BRESET = 2'd3
    } op_e;

    // encoding is {dp, dm}, full-speed polarity
    typedef enum logic [1:0] {
        LN_SE0 = 2'b00,
        LN_K   = 2'b01,
        LN_J   = 2'b10
    } line_e;

    typedef enum logic [1:0] {
        SLOT_DATA,
        SLOT_SE0,
        SLOT_J,
        SLOT_OFF
    } slot_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_SHIFT,
        SQ_GAP,
        SQ_EOP,
        SQ_BRST
    } seq_e;

    typedef struct packed {
        slot_e kind;
        logic  bit_val;
    } slot_t;

    function automatic line_e flip(input line_e l);
        return (l == LN_J) ? LN_K : LN_J;
    endfunction

endpackage

// File: rtl/usbtx_bitclk.sv
module usbtx_bitclk
    import usbtx_pkg::*;
#(
    parameter int unsigned FS_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic slow,
    output logic tick
);
    localparam int unsigned LS_DIV = FS_DIV * LS_RATIO;
    localparam int unsigned CW     = $clog2(LS_DIV);
    localparam logic [CW-1:0] FS_LAST = CW'(FS_DIV - 1);
    localparam logic [CW-1:0] LS_LAST = CW'(LS_DIV - 1);

    logic [CW-1:0] cnt;

    assign tick = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= slow ? LS_LAST : FS_LAST;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
        (tick && !restart) |=> !tick); // R2

endmodule

// File: rtl/usbtx_nrzi.sv
module usbtx_nrzi
    import usbtx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  tick,
    input  slot_t slot,
    output line_e line,
    output logic  oe,
    output logic  stuff_due
);
    line_e      lvl;
    logic [2:0] ones;

    assign stuff_due = (ones == 3'(STUFF_RUN));

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl  <= LN_J;
            line <= LN_J;
            oe   <= 1'b0;
            ones <= '0;
        end else if (tick) begin
            case (slot.kind)
                SLOT_DATA: begin
                    oe <= 1'b1;
                    if (stuff_due || !slot.bit_val) begin
                        lvl  <= flip(lvl);
                        line <= flip(lvl);
                        ones <= '0;
                    end else begin
                        line <= lvl;
                        ones <= ones + 3'd1;
                    end
                end
                SLOT_SE0: begin
                    oe   <= 1'b1;
                    line <= LN_SE0;
                    lvl  <= LN_J;
                    ones <= '0;
                end
                SLOT_J: begin
                    oe   <= 1'b1;
                    line <= LN_J;
                    lvl  <= LN_J;
                    ones <= '0;
                end
                default: begin
                    oe   <= 1'b0;
                    line <= LN_J;
                    lvl  <= LN_J;
                    ones <= '0;
                end
            endcase
        end
    end

    AST_STUFF_TOGGLES: assert property (@(posedge clk) disable iff (rst)
        (tick && slot.kind == SLOT_DATA && stuff_due) |=> (line != $past(line))); // R3

    AST_RELEASED_AT_J: assert property (@(posedge clk) disable iff (rst)
        !oe |-> (line == LN_J)); // R1

endmodule

// File: rtl/usbtx_rxrate.sv
module usbtx_rxrate #(
    parameter int unsigned RESP_TO = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic reply,
    output logic rx_low
);
    localparam int unsigned TW = $clog2(RESP_TO + 1);
    localparam logic [TW-1:0] TO_LAST = TW'(RESP_TO - 1);

    logic [TW-1:0] wait_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_low   <= 1'b0;
            wait_cnt <= '0;
        end else if (arm) begin
            rx_low   <= 1'b1;
            wait_cnt <= '0;
        end else if (rx_low) begin
            if (reply || wait_cnt == TO_LAST) begin
                rx_low <= 1'b0;
            end else begin
                wait_cnt <= wait_cnt + 1'b1;
            end
        end
    end

    AST_RX_ONLY_ARMED: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_low) |-> $past(arm)); // R10

    AST_RX_REPLY_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (rx_low && reply && !arm) |=> !rx_low); // R10

endmodule

// File: rtl/usb_host_tx_seq.sv
module usb_host_tx_seq
    import usbtx_pkg::*;
#(
    parameter int unsigned FS_DIV     = 4,
    parameter int unsigned GAP_BITS   = 4,
    parameter int unsigned RESET_BITS = 24,
    parameter int unsigned RESP_TO    = 200,
    parameter int unsigned LEN_W      = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [LEN_W-1:0] cmd_len,
    input  logic [7:0]       tx_byte,
    output logic             byte_ack,
    input  logic             rx_reply,
    output logic             usb_dp,
    output logic             usb_dm,
    output logic             usb_oe,
    output logic             busy,
    output logic             done,
    output logic             rx_low
);
    localparam int unsigned CNT_MAX = (RESET_BITS > GAP_BITS) ? RESET_BITS : GAP_BITS;
    localparam int unsigned CNT_W   = $clog2(CNT_MAX + 4);
    localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(GAP_BITS - 1);
    localparam logic [CNT_W-1:0] RST_SPAN = CNT_W'(RESET_BITS);

    seq_e             state, state_n;
    logic [7:0]       shreg, shreg_n;
    logic [2:0]       bit_i, bit_n;
    logic [LEN_W-1:0] left, left_n, save_len, save_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic             pre_q, pre_n, low_q, low_n;
    logic             done_q, ack_q, ack_n;
    logic             restart, finish, tick, stuff_due;
    slot_t            slot;
    line_e            line;

    usbtx_bitclk #(.FS_DIV(FS_DIV)) u_bitclk (
        .clk(clk), .rst(rst), .restart(restart), .slow(low_q), .tick(tick)
    );

    usbtx_nrzi u_nrzi (
        .clk(clk), .rst(rst), .tick(tick), .slot(slot),
        .line(line), .oe(usb_oe), .stuff_due(stuff_due)
    );

    usbtx_rxrate #(.RESP_TO(RESP_TO)) u_rxrate (
        .clk(clk), .rst(rst), .arm(finish && low_q), .reply(rx_reply), .rx_low(rx_low)
    );

    always_comb begin
        state_n = state;
        shreg_n = shreg;
        bit_n   = bit_i;
        left_n  = left;
        save_n  = save_len;
        pre_n   = pre_q;
        low_n   = low_q;
        cnt_n   = cnt;
        restart = 1'b0;
        finish  = 1'b0;
        ack_n   = 1'b0;
        slot    = '{kind: SLOT_OFF, bit_val: 1'b0};
        case (state)
            SQ_IDLE: begin
                if (cmd_valid) begin
                    case (op_e'(cmd_op))
                        OP_FULL: begin
                            state_n = SQ_SHIFT;
                            shreg_n = SYNC_PAT;
                            bit_n   = '0;
                            left_n  = cmd_len;
                            pre_n   = 1'b0;
                            restart = 1'b1;
                        end
                        OP_LOW: begin
                            state_n = SQ_SHIFT;
                            shreg_n = SYNC_PAT;
                            bit_n   = '0;
                            left_n  = LEN_W'(1);
                            save_n  = cmd_len;
                            pre_n   = 1'b1;
                            restart = 1'b1;
                        end
                        OP_BRESET: begin
                            state_n = SQ_BRST;
                            cnt_n   = '0;
                            restart = 1'b1;
                        end
                        default: ;
                    endcase
                end
            end
            SQ_SHIFT: begin
                slot = '{kind: SLOT_DATA, bit_val: shreg[0]};
                if (tick && !stuff_due) begin
                    shreg_n = {1'b0, shreg[7:1]};
                    bit_n   = bit_i + 3'd1;
                    if (bit_i == 3'd7) begin
                        if (left != '0) begin
                            left_n = left - 1'b1;
                            if (pre_q) begin
                                shreg_n = PRE_TOKEN;
                            end else begin
                                shreg_n = tx_byte;
                                ack_n   = 1'b1;
                            end
                        end else begin
                            state_n = pre_q ? SQ_GAP : SQ_EOP;
                            cnt_n   = '0;
                        end
                    end
                end
            end
            SQ_GAP: begin
                // J at full speed; the switch to the slow rate lands on the next bit boundary
                slot = '{kind: SLOT_J, bit_val: 1'b1};
                if (tick) begin
                    if (cnt == GAP_LAST) begin
                        state_n = SQ_SHIFT;
                        shreg_n = SYNC_PAT;
                        bit_n   = '0;
                        left_n  = save_len;
                        pre_n   = 1'b0;
                        low_n   = 1'b1;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
            end
            SQ_EOP: begin
                if (stuff_due) begin
                    slot = '{kind: SLOT_DATA, bit_val: 1'b1};
                end else if (cnt < CNT_W'(2)) begin
                    slot = '{kind: SLOT_SE0, bit_val: 1'b0};
                    if (tick) cnt_n = cnt + 1'b1;
                end else if (cnt == CNT_W'(2)) begin
                    slot = '{kind: SLOT_J, bit_val: 1'b1};
                    if (tick) cnt_n = cnt + 1'b1;
                end else if (tick) begin
                    finish  = 1'b1;
                    state_n = SQ_IDLE;
                    low_n   = 1'b0;
                end
            end
            SQ_BRST: begin
                if (cnt < RST_SPAN) begin
                    slot = '{kind: SLOT_SE0, bit_val: 1'b0};
                    if (tick) cnt_n = cnt + 1'b1;
                end else if (tick) begin
                    finish  = 1'b1;
                    state_n = SQ_IDLE;
                end
            end
            default: state_n = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SQ_IDLE;
            shreg    <= '0;
            bit_i    <= '0;
            left     <= '0;
            save_len <= '0;
            pre_q    <= 1'b0;
            low_q    <= 1'b0;
            cnt      <= '0;
            done_q   <= 1'b0;
            ack_q    <= 1'b0;
        end else begin
            state    <= state_n;
            shreg    <= shreg_n;
            bit_i    <= bit_n;
            left     <= left_n;
            save_len <= save_n;
            pre_q    <= pre_n;
            low_q    <= low_n;
            cnt      <= cnt_n;
            done_q   <= finish;
            ack_q    <= ack_n;
        end
    end

    assign usb_dp   = line[1];
    assign usb_dm   = line[0];
    assign busy     = (state != SQ_IDLE);
    assign done     = done_q;
    assign byte_ack = ack_q;

    AST_PRE_NO_SE0: assert property (@(posedge clk) disable iff (rst)
        pre_q |-> (line != LN_SE0)); // R5

    AST_SLOW_AFTER_GAP: assert property (@(posedge clk) disable iff (rst)
        $rose(low_q) |-> ($past(state) == SQ_GAP)); // R7

    AST_IDLE_FULL_RATE: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_IDLE) |-> !low_q); // R8

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q); // R4

endmodule

// File: tb/usb_host_tx_seq_tb.sv
module usb_host_tx_seq_tb;
    localparam int FSD  = 4;
    localparam int LSD  = FSD * 8;
    localparam int GAP  = 4;
    localparam int RSTB = 24;
    localparam int RTO  = 200;
    localparam logic [1:0] J = 2'b10, K = 2'b01, Z = 2'b00;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'd0;
    logic [3:0] cmd_len = 4'd0;
    logic [7:0] tx_byte;
    logic       byte_ack, rx_reply = 1'b0;
    logic       usb_dp, usb_dm, usb_oe, busy, done, rx_low;

    int checks = 0;
    int fails  = 0;
    logic [7:0] pkt [0:15];
    int ack_cnt = 0;
    logic feed_clr = 1'b0;
    logic [1:0] cap [$];
    logic [1:0] expq [$];
    logic [1:0] lvl;
    int ones;

    always #5 clk = ~clk;

    usb_host_tx_seq #(.FS_DIV(FSD), .GAP_BITS(GAP), .RESET_BITS(RSTB),
                      .RESP_TO(RTO), .LEN_W(4)) u_dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_len(cmd_len), .tx_byte(tx_byte), .byte_ack(byte_ack),
        .rx_reply(rx_reply), .usb_dp(usb_dp), .usb_dm(usb_dm),
        .usb_oe(usb_oe), .busy(busy), .done(done), .rx_low(rx_low)
    );

    assign tx_byte = pkt[ack_cnt[3:0]];

    always @(negedge clk) begin
        if (feed_clr) ack_cnt <= 0;
        else if (byte_ack) ack_cnt <= ack_cnt + 1;
        if (usb_oe) cap.push_back({usb_dp, usb_dm});
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic put(input logic [1:0] v, input int n);
        for (int i = 0; i < n; i++) expq.push_back(v);
    endtask

    task automatic enc_bit(input logic b, input int n);
        if (b) begin
            put(lvl, n);
            ones++;
            if (ones == 6) begin
                lvl = (lvl == J) ? K : J;
                put(lvl, n);
                ones = 0;
            end
        end else begin
            lvl = (lvl == J) ? K : J;
            put(lvl, n);
            ones = 0;
        end
    endtask

    task automatic enc_byte(input logic [7:0] b, input int n);
        for (int i = 0; i < 8; i++) enc_bit(b[i], n);
    endtask

    task automatic enc_packet(input int len, input int n);
        lvl = J; ones = 0;
        enc_byte(8'h80, n);
        for (int i = 0; i < len; i++) enc_byte(pkt[i], n);
    endtask

    task automatic enc_eop(input int n);
        put(Z, 2 * n);
        put(J, n);
    endtask

    task automatic issue(input logic [1:0] op, input logic [3:0] len);
        @(negedge clk);
        cap.delete();
        feed_clr = 1'b1;
        cmd_valid = 1'b1; cmd_op = op; cmd_len = len;
        @(negedge clk);
        feed_clr = 1'b0;
        cmd_valid = 1'b0; cmd_op = 2'd0;
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while (!done && n < 20000) begin
            @(negedge clk);
            n++;
        end
        chk(done === 1'b1, req, int'(done), 1);
    endtask

    task automatic compare_wave(input string req);
        int bad = -1;
        chk(cap.size() == expq.size(), req, cap.size(), expq.size());
        for (int i = 0; i < cap.size() && i < expq.size(); i++)
            if (bad < 0 && cap[i] !== expq[i]) bad = i;
        if (bad >= 0) chk(1'b0, req, int'(cap[bad]), int'(expq[bad]));
        else chk(1'b1, req, 0, 0);
    endtask

    task automatic after_done(input string req, input int len);
        chk(usb_oe == 1'b0 && busy == 1'b0, req, int'({usb_oe, busy}), 0);
        @(negedge clk);
        chk(done == 1'b0, {req, " done width"}, int'(done), 0);
        chk(ack_cnt == len, "R12 byte count", ack_cnt, len);
    endtask

    task automatic t_reset_state();
        chk(usb_oe == 0 && usb_dp == 1 && usb_dm == 0, "R1 line", int'({usb_oe, usb_dp, usb_dm}), 2);
        chk(busy == 0 && done == 0 && rx_low == 0 && byte_ack == 0, "R1 flags",
            int'({busy, done, rx_low, byte_ack}), 0);
    endtask

    task automatic t_full_basic();
        pkt[0] = 8'hC3; pkt[1] = 8'hA5; pkt[2] = 8'h00;
        expq.delete(); enc_packet(3, FSD); enc_eop(FSD);
        issue(2'd1, 4'd3);
        wait_done("R4 full done");
        compare_wave("R2 full packet");
        chk(rx_low == 0, "R10 full leaves rx rate", int'(rx_low), 0);
        after_done("R4", 3);
    endtask

    task automatic t_full_stuff();
        pkt[0] = 8'h4B; pkt[1] = 8'hFF; pkt[2] = 8'hFC;
        expq.delete(); enc_packet(3, FSD); enc_eop(FSD);
        issue(2'd1, 4'd3);
        wait_done("R3 stuff done");
        compare_wave("R3 stuffing incl before EOP");
        after_done("R3", 3);
    endtask

    task automatic t_ignored();
        pkt[0] = 8'h5A; pkt[1] = 8'h96;
        expq.delete(); enc_packet(2, FSD); enc_eop(FSD);
        issue(2'd1, 4'd2);
        repeat (20) @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd3;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 2'd0;
        wait_done("R11 done");
        compare_wave("R11 busy command dropped");
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd0; cmd_len = 4'd5;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (20) @(negedge clk);
        chk(busy == 0 && usb_oe == 0, "R11 code 0 dropped", int'({busy, usb_oe}), 0);
    endtask

    task automatic t_low(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
        pkt[0] = b0; pkt[1] = b1; pkt[2] = b2;
        expq.delete();
        lvl = J; ones = 0;
        enc_byte(8'h80, FSD);
        enc_byte(8'h3C, FSD);
        put(J, GAP * FSD);
        enc_packet(3, LSD);
        enc_eop(LSD);
        issue(2'd2, 4'd3);
        wait_done("R5 low done");
        compare_wave("R5 R6 R7 preamble gap low packet");
        chk(rx_low == 1, "R10 rx_low with done", int'(rx_low), 1);
        after_done("R4 low", 3);
    endtask

    task automatic t_timeout();
        int n = 2;
        t_low(8'hC3, 8'hFF, 8'h01);
        while (rx_low && n < 5000) begin
            @(negedge clk);
            if (rx_low) n++;
        end
        chk(n == RTO, "R10 timeout length", n, RTO);
    endtask

    task automatic t_full_after_low();
        pkt[0] = 8'h2D; pkt[1] = 8'h10;
        expq.delete(); enc_packet(2, FSD); enc_eop(FSD);
        issue(2'd1, 4'd2);
        wait_done("R8 done");
        compare_wave("R8 full rate restored");
    endtask

    task automatic t_reply();
        t_low(8'h69, 8'h81, 8'h7E);
        repeat (5) @(negedge clk);
        chk(rx_low == 1, "R10 held until reply", int'(rx_low), 1);
        rx_reply = 1'b1;
        @(negedge clk);
        rx_reply = 1'b0;
        chk(rx_low == 0, "R10 reply clears", int'(rx_low), 0);
    endtask

    task automatic t_bus_reset();
        expq.delete(); put(Z, RSTB * FSD);
        issue(2'd3, 4'd0);
        wait_done("R9 done");
        compare_wave("R9 reset SE0 span");
        chk(usb_oe == 0 && usb_dp == 1 && usb_dm == 0, "R9 release", int'({usb_oe, usb_dp, usb_dm}), 2);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) pkt[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_full_basic();
        t_full_stuff();
        t_ignored();
        t_timeout();
        t_full_after_low();
        t_reply();
        t_bus_reset();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule